// File: doc/BRIEF.md
# Debug Freeze Controller

This block owns the processor-wide freeze line used by a software monitor debugger while hardware debug mode is off. Execution still flows through ordinary interrupt handlers in that mode. This block only decides whether peripherals see freeze, and it never steers execution. It holds two registers. The enable mask selects which debug events may raise freeze. The cause register records each enabled event that occurred and clears itself when software reads it.

Freeze rises one cycle after any enabled event. It falls only when a return-from-interrupt strobe arrives while the cause register is empty. A monitor that re-enters itself can therefore return several times without dropping freeze, as long as it leaves the cause register unread. It reads the register to clear it only before its outermost return.

Software reaches both registers through a single-cycle bus with a one-bit select. Select 0 picks the enable mask and select 1 picks the cause register. Read data is combinational and is valid in the cycle the read strobe is high.

Top module: `dbgfz_ctrl`

## Requirements
- R1: After reset, the enable mask, the cause register and freeze are all zero.
- R2: A write with select 0 stores the low event-width bits into the enable mask from the next cycle on, and a read with select 0 returns them, with bits above the event width reading zero.
- R3: Cause bit i sets in the cycle after event input i is high while enable bit i is 1, and stays set until a cause read. An event whose enable bit is 0 sets no cause bit.
- R4: Freeze is 1 in the cycle after any event input is high whose enable bit is 1. Events that are only masked ones leave freeze unchanged.
- R5: A read with select 1 returns the current cause bits, and the cause register is zero in the next cycle unless R6 applies.
- R6: An enabled event in the same cycle as a cause read is kept: after the read, the cause register holds exactly that event's bits.
- R7: A return strobe while the cause register is nonzero leaves freeze at 1, however many times it repeats.
- R8: A return strobe while the cause register is zero, with no enabled event in that cycle, makes freeze 0 in the next cycle.
- R9: An enabled event and a return strobe in the same cycle, with the cause register zero, leave freeze at 1.
- R10: A write with select 1 has no effect on the cause register or the enable mask.
- R11: An event in the same cycle as an enable-mask write is qualified by the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | EVT_W | Debug event vector, one bit per event |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| bus_sel_i | input | 1 | Register select: 0 enable mask, 1 cause |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; a read with select 1 clears the cause register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the selected register |
| freeze_o | output | 1 | Freeze line, driven straight from a flip-flop |

## Verification
The bench sweeps every enable mask of an 8-bit build against every single-bit event and the all-ones event. A design that ignored the mask, or that used the wrong bit, would show the wrong cause value or a spurious freeze. Directed sequences cover nested returns, where a design that dropped freeze on any return would fail. They also cover an event arriving during the clearing read, where a design that let the clear win would lose the cause bit. The remaining sequences cover an event arriving together with the final return, a write to the cause register, and an event arriving together with a mask write, where a design that used the new mask would record the event too early.

// File: rtl/dbgfz_pkg.sv
package dbgfz_pkg;

   // One-bit register select on the access bus
   typedef enum logic {
      SEL_ENABLE = 1'b0,
      SEL_CAUSE  = 1'b1
   } dbgfz_sel_e;

endpackage

// File: rtl/dbgfz_enable_reg.sv
module dbgfz_enable_reg #(
   parameter int EVT_W = 32,
   parameter logic [EVT_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [EVT_W-1:0] wdata_i,
   output logic [EVT_W-1:0] mask_o
);

   logic [EVT_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= RESET_VAL;
      else if (wr_i)
         mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   // Written value shows up one cycle later
   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));

   // Mask holds when not written
   assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/dbgfz_cause_reg.sv
module dbgfz_cause_reg #(
   parameter int EVT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic [EVT_W-1:0] mask_i,
   input  logic             clr_i,
   output logic [EVT_W-1:0] cause_o,
   output logic             hit_o,
   output logic             empty_o
);

   logic [EVT_W-1:0] qual;
   logic [EVT_W-1:0] cause_q;

   assign qual = evt_i & mask_i;

   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      // Per-bit sticky cell: a set wins over the read clear
      always_ff @(posedge clk) begin
         if (!rst_n)
            cause_q[i] <= 1'b0;
         else if (qual[i])
            cause_q[i] <= 1'b1;
         else if (clr_i)
            cause_q[i] <= 1'b0;
      end
   end

   assign cause_o = cause_q;
   assign hit_o   = |qual;
   assign empty_o = (cause_q == '0);

   // Bits stay set unless cleared by a read
   assert_cause_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

   // New bits only from enabled events
   assert_cause_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(evt_i & mask_i)) == '0));

   // Read with nothing arriving empties the register
   assert_cause_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && ((evt_i & mask_i) == '0)) |=> (cause_o == '0));

   // Read with arrivals leaves exactly the arrivals
   assert_cause_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cause_o == $past(evt_i & mask_i)));

endmodule

// File: rtl/dbgfz_freeze_ctl.sv
module dbgfz_freeze_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic rfi_i,
   input  logic cause_empty_i,
   output logic freeze_o
);

   logic freeze_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         freeze_q <= 1'b0;
      else if (hit_i)
         freeze_q <= 1'b1;
      else if (rfi_i && cause_empty_i)
         freeze_q <= 1'b0;
   end

   assign freeze_o = freeze_q;

   assert_freeze_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> freeze_o);

   assert_freeze_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && rfi_i && !cause_empty_i) |=> freeze_o);

   assert_freeze_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi_i && cause_empty_i && !hit_i) |=> !freeze_o);

   assert_freeze_only_on_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && !rfi_i) |=> freeze_o);

   assert_freeze_tie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && rfi_i && cause_empty_i) |=> freeze_o);

endmodule

// File: rtl/dbgfz_ctrl.sv
module dbgfz_ctrl #(
   parameter int DATA_W = 32,
   parameter int EVT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic              rfi_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              freeze_o
);
   import dbgfz_pkg::*;

   localparam int PAD_W = DATA_W - EVT_W;

   if (EVT_W < 1 || EVT_W > DATA_W) begin : g_bad_width
      $error("dbgfz_ctrl: EVT_W must be between 1 and DATA_W");
   end

   logic             sel_cause;
   logic             der_wr;
   logic             cause_clr;
   logic [EVT_W-1:0] mask;
   logic [EVT_W-1:0] cause;
   logic             hit;
   logic             empty;
   logic [EVT_W-1:0] rd_sel;

   assign sel_cause = (dbgfz_sel_e'(bus_sel_i) == SEL_CAUSE);
   assign der_wr    = bus_wr_i && !sel_cause;
   assign cause_clr = bus_rd_i && sel_cause;

   dbgfz_enable_reg #(.EVT_W(EVT_W)) u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (der_wr),
      .wdata_i (bus_wdata_i[EVT_W-1:0]),
      .mask_o  (mask)
   );

   dbgfz_cause_reg #(.EVT_W(EVT_W)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .mask_i  (mask),
      .clr_i   (cause_clr),
      .cause_o (cause),
      .hit_o   (hit),
      .empty_o (empty)
   );

   dbgfz_freeze_ctl u_freeze (
      .clk           (clk),
      .rst_n         (rst_n),
      .hit_i         (hit),
      .rfi_i         (rfi_i),
      .cause_empty_i (empty),
      .freeze_o      (freeze_o)
   );

   assign rd_sel = sel_cause ? cause : mask;

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata_o = {{PAD_W{1'b0}}, rd_sel};
   end else begin : g_nopad
      assign bus_rdata_o = rd_sel;
   end

   // A write aimed at the cause register leaves it unchanged (no event, no read)
   assert_cause_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && sel_cause && !bus_rd_i && !hit) |=> $stable(cause));

endmodule

// File: tb/dbgfz_ctrl_test.sv
module dbgfz_ctrl_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] evt = '0;
   logic         rfi = 1'b0;
   logic         sel = 1'b0;
   logic         wr = 1'b0;
   logic         rd = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         freeze;

   int nchk = 0;
   int nbad = 0;

   always #5 clk = ~clk;

   dbgfz_ctrl #(.DATA_W(W), .EVT_W(W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .rfi_i       (rfi),
      .bus_sel_i   (sel),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .freeze_o    (freeze)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic s, input logic [W-1:0] d);
      @(negedge clk); sel = s; wr = 1'b1; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic s, output logic [W-1:0] d);
      @(negedge clk); sel = s; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic pulse_evt(input logic [W-1:0] v);
      @(negedge clk); evt = v;
      @(negedge clk); evt = '0;
   endtask

   task automatic pulse_rfi();
      @(negedge clk); rfi = 1'b1;
      @(negedge clk); rfi = 1'b0;
   endtask

   initial begin
      #2000000;
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      logic [W-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1 chk("R1 freeze", freeze, 0);
      rd_reg(1'b0, d); chk("R1 enable mask", d, 0);
      rd_reg(1'b1, d); chk("R1 cause", d, 0);

      // Sweep all masks against single-bit and all-ones events (R2 R3 R4 R5 R8)
      for (int m = 0; m < 256; m++) begin
         wr_reg(1'b0, W'(m));
         rd_reg(1'b0, d); chk("R2 mask readback", d, m);
         for (int b = 0; b < W; b++) begin
            pulse_evt(W'(1 << b));
            chk("R4 freeze after event", freeze, (m >> b) & 1);
            rd_reg(1'b1, d); chk("R3 cause bit", d, (1 << b) & m);
            rd_reg(1'b1, d); chk("R5 cause cleared", d, 0);
            pulse_rfi();
            chk("R8 freeze after clean return", freeze, 0);
         end
         pulse_evt('1);
         chk("R4 freeze all events", freeze, (m != 0) ? 1 : 0);
         rd_reg(1'b1, d); chk("R3 cause all events", d, m);
         pulse_rfi();
         chk("R8 freeze drop", freeze, 0);
      end

      // R7: nested returns keep freeze while cause is nonzero
      wr_reg(1'b0, 8'hFF);
      pulse_evt(8'h01);
      chk("R4 freeze set", freeze, 1);
      pulse_rfi(); chk("R7 first nested return", freeze, 1);
      pulse_rfi(); chk("R7 second nested return", freeze, 1);
      rd_reg(1'b1, d); chk("R5 cause before final return", d, 8'h01);
      chk("R7 freeze after read only", freeze, 1);
      pulse_rfi(); chk("R8 final return", freeze, 0);

      // R6: event during the clearing read is kept
      pulse_evt(8'h01);
      @(negedge clk); sel = 1'b1; rd = 1'b1; evt = 8'h04;
      #1 chk("R5 read value", rdata, 8'h01);
      @(negedge clk); rd = 1'b0; evt = '0;
      rd_reg(1'b1, d); chk("R6 event kept", d, 8'h04);
      chk("R7 freeze still set", freeze, 1);

      // R9: event together with a clean return keeps freeze
      @(negedge clk); rfi = 1'b1; evt = 8'h02;
      @(negedge clk); rfi = 1'b0; evt = '0;
      chk("R9 freeze held", freeze, 1);

      // R10: write aimed at cause register is ignored
      wr_reg(1'b1, 8'hF0);
      rd_reg(1'b0, d); chk("R10 mask untouched", d, 8'hFF);
      rd_reg(1'b1, d); chk("R10 cause untouched", d, 8'h02);
      pulse_rfi(); chk("R8 freeze drop after R9", freeze, 0);

      // R11: event alongside a mask write uses the old mask
      wr_reg(1'b0, 8'h00);
      @(negedge clk); sel = 1'b0; wr = 1'b1; wdata = 8'h08; evt = 8'h08;
      @(negedge clk); wr = 1'b0; evt = '0;
      chk("R11 freeze not raised", freeze, 0);
      rd_reg(1'b1, d); chk("R11 cause empty", d, 0);
      pulse_evt(8'h08);
      chk("R11 new mask active", freeze, 1);
      rd_reg(1'b1, d); chk("R11 cause with new mask", d, 8'h08);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule